// File: doc/BRIEF.md
# Polled Byte Port Controller

This block sits between a host and a byte-wide peripheral and lets the host move single bytes by polling. The host sees a window of four registers on a small synchronous register bus. One register holds an outgoing byte. One returns the last byte received. A status register reports progress, and a control register chooses the direction and starts a transfer.

The host starts a command in four steps. It polls the status register until the busy flag reads zero. It loads the outgoing byte if one is needed. It writes the direction bits, then writes them again with the go bit set. The controller raises busy, runs the byte across a valid/ready channel toward the device and then closes the command in one step: it drops go and busy together and records whether the device reported an error. The host learns that the command has finished only by reading busy and go. The design has no interrupt path.

Top module: `pio_port_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, every register reads zero: received byte, outgoing byte, status and control. The device-side `dev_tx_valid` and `dev_rx_ready` are low.
- R2: The register map is on `reg_addr`. Address 0 is the received byte (read-only). Address 1 is the outgoing byte. Address 2 is status, with busy in bit 0 and error in bit 1 (read-only). Address 3 is control, with write-direction in bit 0, read-direction in bit 1 and go in bit 2. Read data appears on `reg_rdata` the cycle after the clock edge that samples `reg_rd`.
- R3: One clock edge after go is first seen, busy is set. The device channel stays idle for that cycle and for the cycle after the host write.
- R4: A write command drives the outgoing byte on `dev_tx_data` with `dev_tx_valid` high. Both hold stable until the edge where `dev_tx_ready` is also high. Exactly one byte moves.
- R5: A read command raises `dev_rx_ready`. On the edge where `dev_rx_valid` is also high, `dev_rx_data` is latched into the received-byte register.
- R6: A successful transfer clears go, busy and error on the same edge. This includes clearing an error left by an earlier command.
- R7: If `dev_err` is high during a transfer, the error bit is set and go and busy still clear. The received byte stays unchanged, even if `dev_rx_valid` is high in that cycle.
- R8: While busy is set, host writes to the outgoing byte and to control have no effect.
- R9: When both direction bits are set, the write direction wins. When neither is set, the command completes at once with the error bit set.
- R10: Host writes to address 0 and address 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 2 | Register select |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| dev_tx_data | output | DATA_W | Byte toward the device |
| dev_tx_valid | output | 1 | Outgoing byte valid |
| dev_tx_ready | input | 1 | Device accepts outgoing byte |
| dev_rx_data | input | DATA_W | Byte from the device |
| dev_rx_valid | input | 1 | Incoming byte valid |
| dev_rx_ready | output | 1 | Controller accepts incoming byte |
| dev_err | input | 1 | Device reports a failed transfer |

## Verification
The bench holds `dev_tx_ready` low across many cycles to confirm that the outgoing byte and valid do not change. A design that let data follow the outgoing register would corrupt the byte in flight. It raises `dev_err` together with a valid incoming byte. A design that gave data priority over error would overwrite the received byte. Host writes are sent during busy to find a design that lets them reach the register file. The bench also sends commands with both direction bits set and with neither, which exposes wrong priority and a controller that hangs forever with no direction. A final successful transfer after a failed one shows whether the error bit is cleared again.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam logic [1:0] ADDR_DIN  = 2'd0;
  localparam logic [1:0] ADDR_DOUT = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  localparam int unsigned CTRL_W = 3;

  typedef struct packed {
    logic go;
    logic rd;
    logic wr;
  } pio_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCEPT  = 2'd1,
    ST_XFER_WR = 2'd2,
    ST_XFER_RD = 2'd3
  } pio_state_e;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pio_host_regs.sv
module pio_host_regs
  import pio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              err,
  input  logic [DATA_W-1:0] data_in,
  input  logic              go_clr,
  output logic [DATA_W-1:0] data_out,
  output pio_ctrl_t         ctrl
);
  localparam int unsigned PAD_W = DATA_W - CTRL_W;

  logic [DATA_W-1:0] dout_q, dout_d, rdata_q, rdata_d;
  pio_ctrl_t         ctrl_q, ctrl_d;
  logic              wr_ok, dout_en, ctrl_en, rdata_en;

  always_comb begin
    wr_ok    = reg_wr && !busy;
    dout_en  = wr_ok && (reg_addr == ADDR_DOUT);
    ctrl_en  = (wr_ok && (reg_addr == ADDR_CTRL)) || go_clr;
    rdata_en = reg_rd;

    dout_d = reg_wdata;
    ctrl_d = ctrl_q;
    if (wr_ok && (reg_addr == ADDR_CTRL)) ctrl_d = pio_ctrl_t'(reg_wdata[CTRL_W-1:0]);
    if (go_clr) ctrl_d.go = 1'b0;

    unique case (reg_addr)
      ADDR_DIN:  rdata_d = data_in;
      ADDR_DOUT: rdata_d = dout_q;
      ADDR_STAT: rdata_d = {{(DATA_W-2){1'b0}}, err, busy};
      default:   rdata_d = {{PAD_W{1'b0}}, ctrl_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (dout_en)  dout_q  <= dout_d;
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign data_out  = dout_q;
  assign ctrl      = ctrl_q;
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pio_ctrl_t         ctrl,
  input  logic [DATA_W-1:0] data_out,
  output logic              busy,
  output logic              err,
  output logic [DATA_W-1:0] data_in,
  output logic              go_clr,
  output logic [DATA_W-1:0] dev_tx_data,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic              dev_err
);
  pio_state_e        state_q, state_d;
  logic              busy_q, busy_d, err_q, err_d;
  logic [DATA_W-1:0] din_q;
  logic              din_en, done, fail;

  always_comb begin
    state_d = state_q;
    busy_d  = busy_q;
    err_d   = err_q;
    din_en  = 1'b0;
    done    = 1'b0;
    fail    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (ctrl.go) begin
          state_d = ST_ACCEPT;
          busy_d  = 1'b1;
        end
      end
      ST_ACCEPT: begin
        if (ctrl.wr)      state_d = ST_XFER_WR;
        else if (ctrl.rd) state_d = ST_XFER_RD;
        else begin
          done = 1'b1;
          fail = 1'b1;
        end
      end
      ST_XFER_WR: begin
        if (dev_err) begin
          done = 1'b1;
          fail = 1'b1;
        end else if (dev_tx_ready) begin
          done = 1'b1;
        end
      end
      default: begin
        if (dev_err) begin
          done = 1'b1;
          fail = 1'b1;
        end else if (dev_rx_valid) begin
          done   = 1'b1;
          din_en = 1'b1;
        end
      end
    endcase

    if (done) begin
      state_d = ST_IDLE;
      busy_d  = 1'b0;
      err_d   = fail;
    end
    go_clr = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      din_q   <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      err_q   <= err_d;
      if (din_en) din_q <= dev_rx_data;
    end
  end

  assign busy         = busy_q;
  assign err          = err_q;
  assign data_in      = din_q;
  assign dev_tx_valid = (state_q == ST_XFER_WR);
  assign dev_tx_data  = data_out;
  assign dev_rx_ready = (state_q == ST_XFER_RD);
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] dev_tx_data,
  output logic              dev_tx_valid,
  input  logic              dev_tx_ready,
  input  logic [DATA_W-1:0] dev_rx_data,
  input  logic              dev_rx_valid,
  output logic              dev_rx_ready,
  input  logic              dev_err
);
  logic              rst_sync_n;
  logic              busy, err, go_clr;
  logic [DATA_W-1:0] data_in, data_out;
  pio_ctrl_t         ctrl;

  pio_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pio_host_regs #(.DATA_W(DATA_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .err       (err),
    .data_in   (data_in),
    .go_clr    (go_clr),
    .data_out  (data_out),
    .ctrl      (ctrl)
  );

  pio_seq #(.DATA_W(DATA_W)) seq_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ctrl         (ctrl),
    .data_out     (data_out),
    .busy         (busy),
    .err          (err),
    .data_in      (data_in),
    .go_clr       (go_clr),
    .dev_tx_data  (dev_tx_data),
    .dev_tx_valid (dev_tx_valid),
    .dev_tx_ready (dev_tx_ready),
    .dev_rx_data  (dev_rx_data),
    .dev_rx_valid (dev_rx_valid),
    .dev_rx_ready (dev_rx_ready),
    .dev_err      (dev_err)
  );
endmodule

// File: rtl/pio_port_ctrl_chk.sv
module pio_port_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [1:0]        reg_addr,
  input logic              reg_wr,
  input logic              busy,
  input logic              err,
  input logic [2:0]        ctrl,
  input logic [DATA_W-1:0] data_in,
  input logic [DATA_W-1:0] data_out,
  input logic [DATA_W-1:0] dev_tx_data,
  input logic              dev_tx_valid,
  input logic              dev_tx_ready,
  input logic              dev_rx_ready,
  input logic              dev_err
);
  p_busy_after_go_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(ctrl[2]));

  p_dev_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dev_tx_valid || dev_rx_ready) |-> busy);

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dev_tx_valid && !dev_tx_ready && !dev_err) |=> (dev_tx_valid && $stable(dev_tx_data)));

  p_done_clears_go_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> !ctrl[2]);

  p_err_keeps_din_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($fell(busy) && err) |-> $stable(data_in));

  p_dout_locked_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && reg_wr && reg_addr == 2'd1) |=> $stable(data_out));

  p_ctrl_locked_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && reg_wr && reg_addr == 2'd3) |=> (ctrl[1:0] == $past(ctrl[1:0])));

  p_one_direction_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dev_tx_valid && dev_rx_ready));
endmodule

bind pio_port_ctrl pio_port_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .reg_addr     (reg_addr),
  .reg_wr       (reg_wr),
  .busy         (busy),
  .err          (err),
  .ctrl         (ctrl),
  .data_in      (data_in),
  .data_out     (data_out),
  .dev_tx_data  (dev_tx_data),
  .dev_tx_valid (dev_tx_valid),
  .dev_tx_ready (dev_tx_ready),
  .dev_rx_ready (dev_rx_ready),
  .dev_err      (dev_err)
);

// File: tb/pio_port_ctrl_tb_top.sv
module pio_port_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr;
  logic       rd, wr;
  logic [7:0] wdata, rdata;
  logic [7:0] tx_data, rx_data;
  logic       tx_valid, tx_ready, rx_valid, rx_ready, dev_err;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  pio_port_ctrl #(.DATA_W(8)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (addr),
    .reg_rd       (rd),
    .reg_wr       (wr),
    .reg_wdata    (wdata),
    .reg_rdata    (rdata),
    .dev_tx_data  (tx_data),
    .dev_tx_valid (tx_valid),
    .dev_tx_ready (tx_ready),
    .dev_rx_data  (rx_data),
    .dev_rx_valid (rx_valid),
    .dev_rx_ready (rx_ready),
    .dev_err      (dev_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  task automatic tx_accept();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    chk("R1 rx_ready", {7'b0, rx_ready}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      hrd(a[1:0], v);
      chk("R1 register zero", v, 8'h00);
    end
  endtask

  task automatic t_write();
    logic [7:0] v;
    hwr(2'd1, 8'hA5);
    hwr(2'd3, 8'h01);
    hwr(2'd3, 8'h05);
    chk("R3 idle before busy", {7'b0, tx_valid}, 8'h00);
    @(negedge clk);
    chk("R3 idle in accept cycle", {7'b0, tx_valid}, 8'h00);
    hrd(2'd2, v);
    chk("R2 R3 status busy", v, 8'h01);
    chk("R4 tx_valid", {7'b0, tx_valid}, 8'h01);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R4 byte held", tx_data, 8'hA5);
      chk("R4 valid held", {7'b0, tx_valid}, 8'h01);
    end
    tx_accept();
    chk("R4 single beat", {7'b0, tx_valid}, 8'h00);
    hrd(2'd2, v); chk("R6 status clear", v, 8'h00);
    hrd(2'd3, v); chk("R6 go cleared", v, 8'h01);
    hrd(2'd1, v); chk("R2 data-out readback", v, 8'hA5);
  endtask

  task automatic t_read();
    logic [7:0] v;
    hwr(2'd3, 8'h06);
    repeat (3) @(negedge clk);
    chk("R5 rx_ready", {7'b0, rx_ready}, 8'h01);
    chk("R5 no tx", {7'b0, tx_valid}, 8'h00);
    rx_data = 8'h3C; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    chk("R5 rx_ready drops", {7'b0, rx_ready}, 8'h00);
    hrd(2'd0, v); chk("R5 byte latched", v, 8'h3C);
    hrd(2'd2, v); chk("R6 status clear after read", v, 8'h00);
    hrd(2'd3, v); chk("R6 go cleared after read", v, 8'h02);
  endtask

  task automatic t_err_write();
    logic [7:0] v;
    hwr(2'd3, 8'h05);
    repeat (3) @(negedge clk);
    dev_err = 1'b1;
    @(negedge clk); dev_err = 1'b0;
    chk("R7 tx stops", {7'b0, tx_valid}, 8'h00);
    hrd(2'd2, v); chk("R7 error set busy clear", v, 8'h02);
    hrd(2'd3, v); chk("R7 go cleared", v, 8'h01);
  endtask

  task automatic t_err_read();
    logic [7:0] v;
    hwr(2'd3, 8'h06);
    repeat (3) @(negedge clk);
    dev_err = 1'b1; rx_valid = 1'b1; rx_data = 8'hFF;
    @(negedge clk); dev_err = 1'b0; rx_valid = 1'b0;
    hrd(2'd2, v); chk("R7 read error status", v, 8'h02);
    hrd(2'd0, v); chk("R7 data-in kept", v, 8'h3C);
  endtask

  task automatic t_recover();
    logic [7:0] v;
    hwr(2'd1, 8'h5A);
    hwr(2'd3, 8'h05);
    repeat (3) @(negedge clk);
    chk("R4 new byte", tx_data, 8'h5A);
    tx_accept();
    hrd(2'd2, v); chk("R6 error cleared by success", v, 8'h00);
  endtask

  task automatic t_busy_lock();
    logic [7:0] v;
    hwr(2'd1, 8'hC3);
    hwr(2'd3, 8'h05);
    hwr(2'd1, 8'h11);
    hwr(2'd3, 8'h00);
    chk("R8 tx byte unchanged", tx_data, 8'hC3);
    hrd(2'd1, v); chk("R8 data-out unchanged", v, 8'hC3);
    hrd(2'd3, v); chk("R8 control unchanged", v, 8'h05);
    tx_accept();
    hrd(2'd3, v); chk("R8 go cleared after locked run", v, 8'h01);
  endtask

  task automatic t_prio();
    logic [7:0] v;
    hwr(2'd3, 8'h07);
    repeat (3) @(negedge clk);
    chk("R9 write wins tx", {7'b0, tx_valid}, 8'h01);
    chk("R9 write wins rx", {7'b0, rx_ready}, 8'h00);
    tx_accept();
    hrd(2'd2, v); chk("R9 both-bits done", v, 8'h00);
    hwr(2'd3, 8'h04);
    repeat (3) @(negedge clk);
    hrd(2'd2, v); chk("R9 no direction error", v, 8'h02);
    hrd(2'd3, v); chk("R9 no direction go cleared", v, 8'h00);
  endtask

  task automatic t_readonly();
    logic [7:0] v;
    hwr(2'd0, 8'h77);
    hwr(2'd2, 8'hFF);
    hrd(2'd0, v); chk("R10 data-in not writable", v, 8'h3C);
    hrd(2'd2, v); chk("R10 status not writable", v, 8'h02);
    chk("R10 no transfer started", {6'b0, rx_ready, tx_valid}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0; dev_err = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_err_write();
    t_err_read();
    t_recover();
    t_busy_lock();
    t_prio();
    t_readonly();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule